// File: doc/BRIEF.md
# Quad Compare-Reload Counter Block

The block holds four identical 16-bit counter channels behind a simple synchronous 16-bit register bus. Each channel advances its counter on the rising edges of a selectable source: an external input pin, or the block clock divided by a power of two from its own prescaler. Depending on a direction bit it counts up toward one compare register or down toward a second one. On a match it can reload the counter from a load register and refresh the matched compare register from its preload register. A match also sets a sticky flag that drives an interrupt line, and it can drive an output flag.

A single enable register in channel 0's window gates all four channels. Software programs a channel by writing its registers and setting the count mode. An interrupt handler then clears the compare flag. Reads return the addressed register in the same cycle that the bus selects it.

Top module: `qtmr`

## Requirements
- R1: A byte address is split into channel = addr[6:5] and word = addr[4:1], and addr[0] is ignored. The byte offsets are: CMPA 0x00, CMPB 0x02, CAPV 0x04, RLD 0x06, HLD 0x08, CNT 0x0A, CFG 0x0C, STAT 0x0E, NXTA 0x10, NXTB 0x12, CSTAT 0x14. Other offsets read 0 and ignore writes. Read data is valid in the same cycle as bus_sel; a write takes effect at the clock edge.
- R2: The RUN register (channel 0, offset 0x1E) holds one enable bit per channel in bits 3:0 and resets to 0xF. The same offset in the other windows reads 0. While its bit is 0, a channel's counter and prescaler hold and no flag is set; register writes still work.
- R3: CFG bits 15:13 select the count mode and bits 12:9 select the source. Mode 1 steps the counter once per source tick; every other mode holds it. Source codes 0..3 tick on a rising edge of ext_in[code], detected against that input's value in the previous cycle. Codes 8..15 tick when the low (code-8) bits of a 7-bit per-channel prescaler are all ones; the prescaler advances every enabled cycle, so 0xF gives one tick per 128 cycles. Codes 4..7 never tick.
- R4: With CFG bit 4 (direction) at 0 the counter counts up and compares against CMPA; at 1 it counts down and compares against CMPB. A compare event is a step taken while the counter equals the selected compare value.
- R5: On a compare event with CFG bit 5 set, the counter takes RLD. With bit 5 clear it steps as usual, wrapping modulo 2^16.
- R6: On a compare event, the compare register in use (CMPA when counting up, CMPB when counting down) takes the value of NXTA or NXTB respectively.
- R7: With CFG bit 6 set, a compare event clears the count-mode field to 0, which stops the channel.
- R8: A compare event sets CSTAT bit 6. Writing CSTAT with bit 6 at 1 clears it. CSTAT bit 7 is the interrupt enable, and irq[n] = CSTAT bit 6 AND bit 7. If a compare event and a clearing write fall in the same cycle, the flag is set.
- R9: STAT bit 15 is set when a step crosses 0xFFFF to 0 (up) or 0 to 0xFFFF (down) without a reload. Writing STAT with bit 15 at 0 clears it, and setting wins over clearing. STAT bit 0 reads oflag.
- R10: CFG bits 2:0 select the output mode. Mode 0 drives oflag high while the channel is enabled and in count mode 1. Mode 1 drives a state that toggles on every compare event and starts at 0. Other modes drive 0.
- R11: A bus write to CNT, CMPA, CMPB or CFG in the same cycle as a step or compare event overrides the change the event would make to that register.
- R12: A read of CNT copies the counter value into HLD at that clock edge. HLD and CAPV are also writable.
- R13: After reset every channel register reads 0, and irq and oflag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address: channel in 6:5, offset in 4:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not selected |
| ext_in | input | 4 | External count sources |
| irq | output | 4 | Per-channel interrupt |
| oflag | output | 4 | Per-channel output flag |

## Verification
Read data is combinational, so the bench compares bus_rdata 1 ns after it drives the address at a falling edge, in the same cycle. Writes, steps, compare events, reloads, flag changes and the HLD snapshot all land on the next rising edge. The bench therefore advances its own model of each channel by one step before that edge and compares irq and oflag at the following falling edge. A write to RUN gates counting from the cycle after the write edge, and the model applies the new enable at the same point. External edges are counted at the edge where the new high level meets a low value from the previous cycle.

// File: rtl/qtmr_pkg.sv
package qtmr_pkg;

   // word index within a channel window (byte offset / 2)
   localparam logic [3:0] RI_CMPA  = 4'h0;
   localparam logic [3:0] RI_CMPB  = 4'h1;
   localparam logic [3:0] RI_CAPV  = 4'h2;
   localparam logic [3:0] RI_RLD   = 4'h3;
   localparam logic [3:0] RI_HLD   = 4'h4;
   localparam logic [3:0] RI_CNT   = 4'h5;
   localparam logic [3:0] RI_CFG   = 4'h6;
   localparam logic [3:0] RI_STAT  = 4'h7;
   localparam logic [3:0] RI_NXTA  = 4'h8;
   localparam logic [3:0] RI_NXTB  = 4'h9;
   localparam logic [3:0] RI_CSTAT = 4'hA;
   localparam logic [3:0] RI_RUN   = 4'hF;

   localparam int WIN_BITS = 5;

   localparam logic [2:0] CM_RISE   = 3'd1;
   localparam logic [2:0] OM_ACTIVE = 3'd0;
   localparam logic [2:0] OM_TOGGLE = 3'd1;

   localparam int CS_FLAG_BIT = 6;
   localparam int CS_IE_BIT   = 7;
   localparam int ST_WRAP_BIT = 15;

   typedef struct packed {
      logic [2:0] mode;
      logic [3:0] psrc;
      logic [1:0] ssrc;
      logic       once;
      logic       length;
      logic       dir;
      logic       coinit;
      logic [2:0] omode;
   } cfg_t;

endpackage

// File: rtl/qtmr_src.sv
module qtmr_src #(
   parameter int NUM_EXT  = 4,
   parameter int PRE_W    = 7,
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [3:0]         psrc,
   input  logic [NUM_EXT-1:0] ext_in,
   output logic               tick
);

   localparam int NUM_DIV = 8;

   if (PRE_W < NUM_DIV - 1) begin : g_bad_pre
      $error("qtmr_src: PRE_W must be at least 7");
   end
   if (NUM_EXT < 1 || NUM_EXT > 8) begin : g_bad_ext
      $error("qtmr_src: NUM_EXT must be 1..8");
   end

   logic [PRE_W-1:0]   pre;
   logic [NUM_EXT-1:0] ext_s, ext_q, rise;
   logic [NUM_DIV-1:0] div_tick;

   if (EXT_SYNC) begin : g_sync
      logic [NUM_EXT-1:0] meta1, meta2;
      always_ff @(posedge clk) begin
         if (rst) begin
            meta1 <= '0;
            meta2 <= '0;
         end else begin
            meta1 <= ext_in;
            meta2 <= meta1;
         end
      end
      assign ext_s = meta2;
   end else begin : g_direct
      assign ext_s = ext_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pre   <= '0;
         ext_q <= '0;
      end else begin
         ext_q <= ext_s;
         if (en) pre <= pre + PRE_W'(1);
      end
   end

   assign rise = ext_s & ~ext_q;

   for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
      localparam logic [PRE_W-1:0] MSK = PRE_W'((1 << k) - 1);
      assign div_tick[k] = ((pre & MSK) == MSK);
   end

   always_comb begin
      tick = 1'b0;
      if (psrc[3]) begin
         tick = div_tick[psrc[2:0]];
      end else begin
         for (int i = 0; i < NUM_EXT; i++) begin
            if (psrc == 4'(i)) tick = rise[i];
         end
      end
   end

   // prescaler holds while the channel is disabled
   p_pre_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(pre));

endmodule

// File: rtl/qtmr_chan.sv
module qtmr_chan
   import qtmr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_EXT  = 4,
   parameter int PRE_W    = 7,
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               acc,
   input  logic               wr,
   input  logic [3:0]         widx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_EXT-1:0] ext_in,
   output logic               irq,
   output logic               oflag
);

   logic [DATA_W-1:0] cmpa, cmpb, capv, rld, hld, cnt, nxta, nxtb;
   cfg_t              cfg;
   logic              cmp_f, ie, wrap_f, tgl;

   logic              tick, active, step, cmp_evt, wrap_evt;
   logic [DATA_W-1:0] cmp_val, cnt_step;
   logic              w_cmpa, w_cmpb, w_capv, w_rld, w_hld, w_cnt, w_cfg;
   logic              w_stat, w_nxta, w_nxtb, w_cstat, rd_cnt;

   assign w_cmpa  = acc && wr && (widx == RI_CMPA);
   assign w_cmpb  = acc && wr && (widx == RI_CMPB);
   assign w_capv  = acc && wr && (widx == RI_CAPV);
   assign w_rld   = acc && wr && (widx == RI_RLD);
   assign w_hld   = acc && wr && (widx == RI_HLD);
   assign w_cnt   = acc && wr && (widx == RI_CNT);
   assign w_cfg   = acc && wr && (widx == RI_CFG);
   assign w_stat  = acc && wr && (widx == RI_STAT);
   assign w_nxta  = acc && wr && (widx == RI_NXTA);
   assign w_nxtb  = acc && wr && (widx == RI_NXTB);
   assign w_cstat = acc && wr && (widx == RI_CSTAT);
   assign rd_cnt  = acc && !wr && (widx == RI_CNT);

   qtmr_src #(
      .NUM_EXT (NUM_EXT),
      .PRE_W   (PRE_W),
      .EXT_SYNC(EXT_SYNC)
   ) u_src (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .psrc  (cfg.psrc),
      .ext_in(ext_in),
      .tick  (tick)
   );

   assign active   = en && (cfg.mode == CM_RISE);
   assign step     = active && tick;
   assign cmp_val  = cfg.dir ? cmpb : cmpa;
   assign cmp_evt  = step && (cnt == cmp_val);
   assign cnt_step = cfg.dir ? (cnt - DATA_W'(1)) : (cnt + DATA_W'(1));
   assign wrap_evt = step && !(cmp_evt && cfg.length) &&
                     (cfg.dir ? (cnt == '0) : (cnt == '1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cmpa   <= '0;
         cmpb   <= '0;
         capv   <= '0;
         rld    <= '0;
         hld    <= '0;
         cnt    <= '0;
         nxta   <= '0;
         nxtb   <= '0;
         cfg    <= '0;
         cmp_f  <= 1'b0;
         ie     <= 1'b0;
         wrap_f <= 1'b0;
         tgl    <= 1'b0;
      end else begin
         if (w_cnt)                     cnt <= wdata;
         else if (cmp_evt && cfg.length) cnt <= rld;
         else if (step)                 cnt <= cnt_step;

         if (w_cmpa)                    cmpa <= wdata;
         else if (cmp_evt && !cfg.dir)  cmpa <= nxta;

         if (w_cmpb)                    cmpb <= wdata;
         else if (cmp_evt && cfg.dir)   cmpb <= nxtb;

         if (w_cfg)                     cfg <= cfg_t'(wdata[15:0]);
         else if (cmp_evt && cfg.once)  cfg.mode <= '0;

         if (w_capv) capv <= wdata;
         if (w_rld)  rld  <= wdata;
         if (w_nxta) nxta <= wdata;
         if (w_nxtb) nxtb <= wdata;

         if (w_hld)       hld <= wdata;
         else if (rd_cnt) hld <= cnt;

         if (cmp_evt)                              cmp_f <= 1'b1;
         else if (w_cstat && wdata[CS_FLAG_BIT])   cmp_f <= 1'b0;
         if (w_cstat)                              ie    <= wdata[CS_IE_BIT];

         if (wrap_evt)                             wrap_f <= 1'b1;
         else if (w_stat && !wdata[ST_WRAP_BIT])   wrap_f <= 1'b0;

         if (cmp_evt) tgl <= ~tgl;
      end
   end

   always_comb begin
      case (cfg.omode)
         OM_ACTIVE: oflag = active;
         OM_TOGGLE: oflag = tgl;
         default:   oflag = 1'b0;
      endcase
   end

   assign irq = cmp_f & ie;

   always_comb begin
      case (widx)
         RI_CMPA:  rdata = cmpa;
         RI_CMPB:  rdata = cmpb;
         RI_CAPV:  rdata = capv;
         RI_RLD:   rdata = rld;
         RI_HLD:   rdata = hld;
         RI_CNT:   rdata = cnt;
         RI_CFG:   rdata = DATA_W'(cfg);
         RI_STAT:  rdata = DATA_W'({wrap_f, 14'b0, oflag});
         RI_NXTA:  rdata = nxta;
         RI_NXTB:  rdata = nxtb;
         RI_CSTAT: rdata = DATA_W'({ie, cmp_f, 6'b0});
         default:  rdata = '0;
      endcase
   end

   p_hold_off_r2: assert property (@(posedge clk) disable iff (rst)
      (!en && !w_cnt) |=> $stable(cnt));

   p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
      (step && !cmp_evt && !cfg.dir && !w_cnt) |=> (cnt == $past(cnt) + DATA_W'(1)));

   p_reload_r5: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt && cfg.length && !w_cnt) |=> (cnt == $past(rld)));

   p_preload_r6: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt && !cfg.dir && !w_cmpa) |=> (cmpa == $past(nxta)));

   p_once_stop_r7: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt && cfg.once && !w_cfg) |=> !active);

   p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (w_cstat && wdata[CS_FLAG_BIT] && !cmp_evt) |=> !irq);

endmodule

// File: rtl/qtmr.sv
module qtmr
   import qtmr_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int DATA_W   = 16,
   parameter int NUM_EXT  = 4,
   parameter int PRE_W    = 7,
   parameter bit EXT_SYNC = 1'b0,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int ADDR_W  = CH_W + WIN_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_EXT-1:0] ext_in,
   output logic [NUM_CH-1:0]  irq,
   output logic [NUM_CH-1:0]  oflag
);

   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("qtmr: NUM_CH must be 2..16");
   end
   if (DATA_W < 16) begin : g_bad_w
      $error("qtmr: DATA_W must be at least 16");
   end

   logic [CH_W-1:0]   sel_ch;
   logic [3:0]        sel_w;
   logic [NUM_CH-1:0] run_en;
   logic              run_hit;
   logic              unused_addr_lsb;
   logic [DATA_W-1:0] ch_rd [NUM_CH];

   assign sel_ch          = bus_addr[ADDR_W-1:WIN_BITS];
   assign sel_w           = bus_addr[WIN_BITS-1:1];
   assign unused_addr_lsb = bus_addr[0];
   assign run_hit         = bus_sel && (sel_ch == '0) && (sel_w == RI_RUN);

   always_ff @(posedge clk) begin
      if (rst)                  run_en <= '1;
      else if (run_hit && bus_wr) run_en <= bus_wdata[NUM_CH-1:0];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      qtmr_chan #(
         .DATA_W  (DATA_W),
         .NUM_EXT (NUM_EXT),
         .PRE_W   (PRE_W),
         .EXT_SYNC(EXT_SYNC)
      ) u_chan (
         .clk   (clk),
         .rst   (rst),
         .en    (run_en[i]),
         .acc   (bus_sel && (sel_ch == CH_W'(i))),
         .wr    (bus_wr),
         .widx  (sel_w),
         .wdata (bus_wdata),
         .rdata (ch_rd[i]),
         .ext_in(ext_in),
         .irq   (irq[i]),
         .oflag (oflag[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ch == CH_W'(i)) bus_rdata = ch_rd[i];
         end
         if (run_hit) bus_rdata = DATA_W'(run_en);
      end
   end

   p_run_reset_r2: assert property (@(posedge clk)
      $fell(rst) |-> (run_en == '1));

endmodule

// File: tb/sim_qtmr.sv
`timescale 1ns/1ps
module sim_qtmr;

   localparam logic [4:0] O_CMPA = 5'h00, O_CMPB = 5'h02, O_CAPV = 5'h04, O_RLD = 5'h06,
                          O_HLD = 5'h08, O_CNT = 5'h0A, O_CFG = 5'h0C, O_STAT = 5'h0E,
                          O_NXTA = 5'h10, O_NXTB = 5'h12, O_CSTAT = 5'h14, O_RUN = 5'h1E;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  ext_in = '0;
   logic [3:0]  irq, oflag;

   qtmr u0 (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .irq(irq), .oflag(oflag)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit finished = 1'b0;
   logic [3:0] ext_v = '0;

   always @(posedge clk) cycles++;

   // ---------------- reference model ----------------
   logic [15:0] m_cmpa [4], m_cmpb [4], m_capv [4], m_rld [4], m_hld [4];
   logic [15:0] m_cnt [4], m_cfg [4], m_nxta [4], m_nxtb [4];
   logic        m_cmpf [4], m_ie [4], m_wrap [4], m_tgl [4];
   logic [6:0]  m_pre [4];
   logic [3:0]  m_en, m_extq;

   task automatic m_reset();
      for (int i = 0; i < 4; i++) begin
         m_cmpa[i] = 0; m_cmpb[i] = 0; m_capv[i] = 0; m_rld[i] = 0; m_hld[i] = 0;
         m_cnt[i] = 0; m_cfg[i] = 0; m_nxta[i] = 0; m_nxtb[i] = 0;
         m_cmpf[i] = 0; m_ie[i] = 0; m_wrap[i] = 0; m_tgl[i] = 0; m_pre[i] = 0;
      end
      m_en = 4'hF; m_extq = 4'h0;
   endtask

   function automatic logic m_oflag(int i);
      logic [2:0] om = m_cfg[i][2:0];
      if (om == 3'd0) return m_en[i] && (m_cfg[i][15:13] == 3'd1);
      if (om == 3'd1) return m_tgl[i];
      return 1'b0;
   endfunction

   function automatic logic [15:0] m_read(logic [6:0] a);
      int i = int'(a[6:5]);
      case (a[4:1])
         4'h0: return m_cmpa[i];
         4'h1: return m_cmpb[i];
         4'h2: return m_capv[i];
         4'h3: return m_rld[i];
         4'h4: return m_hld[i];
         4'h5: return m_cnt[i];
         4'h6: return m_cfg[i];
         4'h7: return {m_wrap[i], 14'b0, m_oflag(i)};
         4'h8: return m_nxta[i];
         4'h9: return m_nxtb[i];
         4'hA: return {8'b0, m_ie[i], m_cmpf[i], 6'b0};
         4'hF: return (i == 0) ? {12'b0, m_en} : 16'h0;
         default: return 16'h0;
      endcase
   endfunction

   task automatic m_step(bit s, bit w, logic [6:0] a, logic [15:0] d, logic [3:0] e);
      logic [3:0] en_next = m_en;
      for (int i = 0; i < 4; i++) begin
         logic hit, tick, step, cmp, wrp, dir, len;
         logic [3:0] ps, wi;
         logic [6:0] msk;
         logic [15:0] cnt0;
         hit = s && (a[6:5] == 2'(i));
         wi  = a[4:1];
         ps  = m_cfg[i][12:9];
         if (ps[3]) begin
            msk  = 7'((1 << ps[2:0]) - 1);
            tick = ((m_pre[i] & msk) == msk);
         end else if (ps < 4) begin
            tick = e[ps[1:0]] & ~m_extq[ps[1:0]];
         end else begin
            tick = 1'b0;
         end
         step = m_en[i] && (m_cfg[i][15:13] == 3'd1) && tick;
         dir  = m_cfg[i][4];
         len  = m_cfg[i][5];
         cmp  = step && (m_cnt[i] == (dir ? m_cmpb[i] : m_cmpa[i]));
         wrp  = step && !(cmp && len) && (dir ? (m_cnt[i] == 16'h0) : (m_cnt[i] == 16'hFFFF));
         cnt0 = m_cnt[i];
         if (hit && w && wi == 4'h5) m_cnt[i] = d;
         else if (cmp && len)        m_cnt[i] = m_rld[i];
         else if (step)              m_cnt[i] = dir ? cnt0 - 16'd1 : cnt0 + 16'd1;
         if (hit && w && wi == 4'h0) m_cmpa[i] = d; else if (cmp && !dir) m_cmpa[i] = m_nxta[i];
         if (hit && w && wi == 4'h1) m_cmpb[i] = d; else if (cmp && dir)  m_cmpb[i] = m_nxtb[i];
         if (hit && w && wi == 4'h2) m_capv[i] = d;
         if (hit && w && wi == 4'h3) m_rld[i] = d;
         if (hit && w && wi == 4'h4) m_hld[i] = d; else if (hit && !w && wi == 4'h5) m_hld[i] = cnt0;
         if (hit && w && wi == 4'h6) m_cfg[i] = d; else if (cmp && m_cfg[i][6]) m_cfg[i][15:13] = 3'd0;
         if (wrp) m_wrap[i] = 1'b1; else if (hit && w && wi == 4'h7 && !d[15]) m_wrap[i] = 1'b0;
         if (hit && w && wi == 4'h8) m_nxta[i] = d;
         if (hit && w && wi == 4'h9) m_nxtb[i] = d;
         if (cmp) m_cmpf[i] = 1'b1; else if (hit && w && wi == 4'hA && d[6]) m_cmpf[i] = 1'b0;
         if (hit && w && wi == 4'hA) m_ie[i] = d[7];
         if (cmp) m_tgl[i] = ~m_tgl[i];
         if (m_en[i]) m_pre[i] = m_pre[i] + 7'd1;
      end
      if (s && w && a[6:1] == 6'h0F) en_next = d[3:0];
      m_en   = en_next;
      m_extq = e;
   endtask

   // ---------------- checking ----------------
   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(string tag, bit s, bit w, logic [6:0] a, logic [15:0] d);
      logic [3:0] exp_irq, exp_of;
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ext_in = ext_v;
      #1;
      if (s && !w) chk(tag, bus_rdata, m_read(a));
      m_step(s, w, a, d, ext_v);
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         exp_irq[i] = m_cmpf[i] & m_ie[i];
         exp_of[i]  = m_oflag(i);
      end
      chk("R8 irq", {12'b0, irq}, {12'b0, exp_irq});
      chk("R10 oflag", {12'b0, oflag}, {12'b0, exp_of});
   endtask

   task automatic wr(int ch, logic [4:0] off, logic [15:0] v);
      cyc("R1 write", 1'b1, 1'b1, {2'(ch), off}, v);
   endtask

   task automatic rd(string tag, int ch, logic [4:0] off);
      cyc(tag, 1'b1, 1'b0, {2'(ch), off}, 16'h0);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc("idle", 1'b0, 1'b0, 7'h0, 16'h0);
   endtask

   function automatic string tag_of(logic [3:0] wi);
      case (wi)
         4'h0, 4'h1, 4'h8, 4'h9: return "R6 compare regs";
         4'h5: return "R4 counter";
         4'h6: return "R7 config";
         4'h7: return "R9 status";
         4'hA: return "R8 flag";
         4'h4: return "R12 hold";
         4'hF: return "R2 run";
         default: return "R1 decode";
      endcase
   endfunction

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd4242));
      m_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R13: reset values
      for (int ch = 0; ch < 4; ch++)
         for (int o = 0; o < 32; o += 2)
            rd((o == 30 && ch == 0) ? "R2 run reset" : "R13 reset value", ch, 5'(o));

      // R4 R5 R6 R8: up count with reload and preload, channel 0 at /1
      wr(0, O_RLD, 16'd2);  wr(0, O_CMPA, 16'd5); wr(0, O_NXTA, 16'd7);
      wr(0, O_CNT, 16'd0);  wr(0, O_CSTAT, 16'h0080);
      wr(0, O_CFG, 16'h3020);
      idle(12);
      rd("R5 reload", 0, O_CNT);
      rd("R6 preload", 0, O_CMPA);
      rd("R8 flag set", 0, O_CSTAT);
      wr(0, O_CSTAT, 16'h00C0);
      rd("R8 flag cleared", 0, O_CSTAT);

      // R3: /128 source on channel 1
      wr(1, O_CMPA, 16'd2); wr(1, O_CNT, 16'd0); wr(1, O_CFG, 16'h3E20);
      idle(300);
      rd("R3 divided source", 1, O_CNT);

      // R4 R9 R10: down count through zero with toggle output
      wr(2, O_CNT, 16'd1); wr(2, O_CMPB, 16'hFFF0); wr(2, O_NXTB, 16'hFFF0);
      wr(2, O_CFG, 16'h3011);
      idle(4);
      rd("R9 wrap set", 2, O_STAT);
      wr(2, O_STAT, 16'h0000);
      rd("R9 wrap cleared", 2, O_STAT);
      rd("R4 down count", 2, O_CNT);
      idle(16);
      rd("R10 toggle", 2, O_STAT);

      // R7: one-shot stop
      wr(2, O_CNT, 16'd0); wr(2, O_CMPA, 16'd3); wr(2, O_CFG, 16'h3060);
      idle(8);
      rd("R7 mode cleared", 2, O_CFG);
      rd("R7 counter stopped", 2, O_CNT);

      // R2: disable channel 0 only
      cyc("R2 run write", 1'b1, 1'b1, {2'd0, O_RUN}, 16'h000E);
      rd("R2 hold", 0, O_CNT);
      idle(5);
      rd("R2 hold", 0, O_CNT);
      rd("R1 run only in window 0", 1, O_RUN);
      cyc("R2 run write", 1'b1, 1'b1, {2'd0, O_RUN}, 16'h000F);

      // R3: external source on channel 3, input 1
      wr(3, O_CNT, 16'd0); wr(3, O_CMPA, 16'hFFFF); wr(3, O_CFG, 16'h2200);
      for (int k = 0; k < 10; k++) begin
         ext_v[1] = ~ext_v[1];
         idle(1 + (k % 2));
      end
      rd("R3 external edges", 3, O_CNT);

      // R11: write to counter wins over the step
      wr(0, O_CNT, 16'h0100);
      rd("R11 write priority", 0, O_CNT);

      // R12: snapshot on counter read
      rd("R4 counter", 0, O_CNT);
      rd("R12 hold snapshot", 0, O_HLD);

      // R1: odd byte address, unmapped offsets
      cyc("R1 odd address", 1'b1, 1'b0, {2'd0, 5'h0B}, 16'h0);
      rd("R1 unmapped", 0, 5'h16);
      wr(1, 5'h18, 16'hBEEF);
      rd("R1 unmapped write", 1, 5'h18);

      // constrained random mix
      for (int n = 0; n < 5000; n++) begin
         int r = int'($urandom % 10);
         int ch = int'($urandom % 4);
         ext_v = 4'($urandom);
         if (r < 3) begin
            logic [3:0] wi;
            logic [15:0] v;
            logic [3:0] srcs [8] = '{4'h0, 4'h1, 4'h3, 4'h5, 4'h8, 4'h9, 4'hA, 4'hF};
            wi = 4'($urandom % 12);
            if (wi == 4'hB) wi = 4'hF;
            case (wi)
               4'h6: v = {(($urandom % 4) == 0) ? 3'd0 : 3'd1, srcs[$urandom % 8],
                          2'($urandom), (($urandom % 4) == 0), 1'($urandom), 1'($urandom),
                          1'($urandom), 3'($urandom % 3)};
               4'hF: v = (($urandom % 3) == 0) ? 16'($urandom % 16) : 16'h000F;
               4'hA, 4'h7: v = 16'($urandom);
               default: v = (($urandom % 5) == 0) ? 16'hFFFF - 16'($urandom % 4)
                                                  : 16'($urandom % 12);
            endcase
            if (wi == 4'hF) ch = 0;
            cyc("R11 random write", 1'b1, 1'b1, {2'(ch), wi, 1'b0}, v);
         end else if (r < 6) begin
            logic [6:0] a = 7'($urandom);
            cyc(tag_of(a[4:1]), 1'b1, 1'b0, a, 16'h0);
         end else begin
            cyc("idle", 1'b0, 1'b0, 7'h0, 16'h0);
         end
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait (cycles >= 150000 || finished);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule